// File: doc/BRIEF.md
# Quadrant Folding Angle Pre/Post Processor

This block wraps a rotation-mode sine/cosine core whose convergence range stops a little short of 100 degrees, so that the pair covers the whole circle. An unsigned full-circle angle arrives with a valid strobe. The two top bits select one of four quadrants. The remaining bits are rescaled into the core's radian fixed-point format. The result is always a first-quadrant angle of 0 to pi/2. This angle goes to the core one cycle later, together with a core-side valid.

The quadrant tag is carried in a shift line whose length equals the core's fixed latency. When the core returns its x (cosine) and y (sine) words, the restore stage reads the tag that belongs to that same input. It then swaps and negates the words so that the outputs are the true cosine and sine of the original angle. Every negation saturates, so the most negative code turns into the most positive one instead of wrapping. The block adds no handshake and no buffering. The core is expected to return exactly one result per accepted angle, after a fixed number of cycles.

Top module: `quad_fold_wrap`

## Requirements
- R1: While rst_n is low, and in the first cycle after it, core_valid and out_valid are both 0.
- R2: One cycle after ang_valid is 1, core_valid is 1. core_angle then equals (ang_in[13:0] * HALF_PI_CODE) >> 14, which never exceeds HALF_PI_CODE (12868, pi/2 with 13 fraction bits). The quadrant tag is ang_in[15:14]: 0 means [0,90), 1 means [90,180), 2 means [180,270), 3 means [270,360).
- R3: A cycle with ang_valid at 0 gives core_valid 0 one cycle later, whatever ang_in holds, and it produces no output.
- R4: For quadrant 0, out_cos = core_res_x and out_sin = core_res_y.
- R5: For quadrant 1, out_cos = -core_res_y and out_sin = core_res_x.
- R6: For quadrant 2, out_cos = -core_res_x and out_sin = -core_res_y.
- R7: For quadrant 3, out_cos = core_res_y and out_sin = -core_res_x.
- R8: Negating -32768 yields +32767 on either output.
- R9: A result presented with core_res_valid exactly CORE_LAT cycles after core_valid is restored with the quadrant of that same input. out_valid and the restored words appear one cycle after core_res_valid, and out_valid is 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ang_valid | input | 1 | Input angle strobe |
| ang_in | input | 16 | Unsigned angle, full scale = 360 degrees |
| core_valid | output | 1 | Folded angle strobe toward the core |
| core_angle | output | 16 | Folded angle, radians, 13 fraction bits |
| core_res_valid | input | 1 | Core result strobe |
| core_res_x | input | 16 | Core cosine word, signed, 15 fraction bits |
| core_res_y | input | 16 | Core sine word, signed, 15 fraction bits |
| out_valid | output | 1 | Restored result strobe |
| out_cos | output | 16 | Restored cosine, signed |
| out_sin | output | 16 | Restored sine, signed |

## Verification
The folded angle and its strobe are due one cycle after the input strobe. The bench's behavioural core model answers exactly CORE_LAT cycles after it sees core_valid. The restored words are due one cycle after that answer, which is CORE_LAT+2 cycles after the input angle. The bench samples on falling edges and files each expected value into a slot keyed by the cycle in which it is due. In every cycle it compares both strobes and, when one is expected, the data words, so early, late or missing results are reported as well as wrong ones.

// File: rtl/qf_pkg.sv
`timescale 1ns/1ps
package qf_pkg;
    // quadrant of the full-circle input; code equals the two angle MSBs
    typedef enum logic [1:0] {
        QD_FIRST  = 2'd0,
        QD_SECOND = 2'd1,
        QD_THIRD  = 2'd2,
        QD_FOURTH = 2'd3
    } quad_e;
endpackage

// File: rtl/qf_fold.sv
`timescale 1ns/1ps
module qf_fold
    import qf_pkg::*;
#(
    parameter int ANG_W        = 16,
    parameter int CORE_W       = 16,
    parameter int HALF_PI_CODE = 12868
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ANG_W-1:0]  in_angle,
    output logic              core_valid,
    output logic [CORE_W-1:0] core_angle,
    output quad_e             fold_quad
);
    localparam int LOW_W  = ANG_W - 2;
    localparam int PROD_W = LOW_W + CORE_W;

    logic [LOW_W-1:0]  low_bits;
    logic [PROD_W-1:0] prod;
    logic [CORE_W-1:0] scaled;
    quad_e             quad_nxt;

    // quadrant base removal is simply dropping the two MSBs
    always_comb begin
        quad_nxt = quad_e'(in_angle[ANG_W-1:ANG_W-2]);
        low_bits = in_angle[LOW_W-1:0];
        prod     = PROD_W'(low_bits) * PROD_W'(HALF_PI_CODE);
        scaled   = CORE_W'(prod >> LOW_W);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_valid <= 1'b0;
            core_angle <= '0;
            fold_quad  <= QD_FIRST;
        end else begin
            core_valid <= in_valid;
            if (in_valid) begin
                core_angle <= scaled;
                fold_quad  <= quad_nxt;
            end
        end
    end

    AST_FOLD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        core_valid |-> (32'(core_angle) <= HALF_PI_CODE)); // R2
endmodule

// File: rtl/qf_tag_delay.sv
`timescale 1ns/1ps
module qf_tag_delay
    import qf_pkg::*;
#(
    parameter int DEPTH = 12
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  d_valid,
    input  quad_e d_tag,
    output logic  q_valid,
    output quad_e q_tag
);
    logic  vld_r [DEPTH];
    quad_e tag_r [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        if (g == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vld_r[g] <= 1'b0;
                    tag_r[g] <= QD_FIRST;
                end else begin
                    vld_r[g] <= d_valid;
                    tag_r[g] <= d_tag;
                end
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vld_r[g] <= 1'b0;
                    tag_r[g] <= QD_FIRST;
                end else begin
                    vld_r[g] <= vld_r[g-1];
                    tag_r[g] <= tag_r[g-1];
                end
            end
        end
    end

    assign q_valid = vld_r[DEPTH-1];
    assign q_tag   = tag_r[DEPTH-1];
endmodule

// File: rtl/qf_restore.sv
`timescale 1ns/1ps
module qf_restore
    import qf_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     res_valid,
    input  logic signed [DATA_W-1:0] res_x,
    input  logic signed [DATA_W-1:0] res_y,
    input  quad_e                    res_tag,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_cos,
    output logic signed [DATA_W-1:0] out_sin
);
    localparam logic signed [DATA_W-1:0] S_MIN = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic signed [DATA_W-1:0] S_MAX = {1'b0, {(DATA_W-1){1'b1}}};

    function automatic logic signed [DATA_W-1:0] neg_sat(input logic signed [DATA_W-1:0] v);
        if (v == S_MIN) return S_MAX;
        return -v;
    endfunction

    logic signed [DATA_W-1:0] cos_nxt;
    logic signed [DATA_W-1:0] sin_nxt;

    always_comb begin
        case (res_tag)
            QD_SECOND: begin cos_nxt = neg_sat(res_y); sin_nxt = res_x;          end
            QD_THIRD:  begin cos_nxt = neg_sat(res_x); sin_nxt = neg_sat(res_y); end
            QD_FOURTH: begin cos_nxt = res_y;          sin_nxt = neg_sat(res_x); end
            default:   begin cos_nxt = res_x;          sin_nxt = res_y;          end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_cos   <= '0;
            out_sin   <= '0;
        end else begin
            out_valid <= res_valid;
            if (res_valid) begin
                out_cos <= cos_nxt;
                out_sin <= sin_nxt;
            end
        end
    end

    AST_FIRST_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_tag == QD_FIRST) |=>
            (out_valid && out_cos == $past(res_x) && out_sin == $past(res_y))); // R4
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_tag == QD_THIRD && res_x == S_MIN) |=> (out_cos == S_MAX)); // R8
endmodule

// File: rtl/quad_fold_wrap.sv
`timescale 1ns/1ps
module quad_fold_wrap
    import qf_pkg::*;
#(
    parameter int ANG_W        = 16,
    parameter int DATA_W       = 16,
    parameter int CORE_LAT     = 12,
    parameter int HALF_PI_CODE = 12868
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ang_valid,
    input  logic [ANG_W-1:0]         ang_in,
    output logic                     core_valid,
    output logic [DATA_W-1:0]        core_angle,
    input  logic                     core_res_valid,
    input  logic signed [DATA_W-1:0] core_res_x,
    input  logic signed [DATA_W-1:0] core_res_y,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_cos,
    output logic signed [DATA_W-1:0] out_sin
);
    quad_e fold_quad;
    logic  dly_valid;
    quad_e dly_tag;

    qf_fold #(
        .ANG_W(ANG_W), .CORE_W(DATA_W), .HALF_PI_CODE(HALF_PI_CODE)
    ) fold_i (
        .clk(clk), .rst_n(rst_n),
        .in_valid(ang_valid), .in_angle(ang_in),
        .core_valid(core_valid), .core_angle(core_angle), .fold_quad(fold_quad)
    );

    qf_tag_delay #(.DEPTH(CORE_LAT)) tagdly_i (
        .clk(clk), .rst_n(rst_n),
        .d_valid(core_valid), .d_tag(fold_quad),
        .q_valid(dly_valid), .q_tag(dly_tag)
    );

    qf_restore #(.DATA_W(DATA_W)) restore_i (
        .clk(clk), .rst_n(rst_n),
        .res_valid(core_res_valid), .res_x(core_res_x), .res_y(core_res_y),
        .res_tag(dly_tag),
        .out_valid(out_valid), .out_cos(out_cos), .out_sin(out_sin)
    );

    // a core answer must line up with a tag launched CORE_LAT cycles earlier
    AST_RES_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        core_res_valid |-> dly_valid); // R9
endmodule

// File: tb/quad_fold_wrap_tb_top.sv
`timescale 1ns/1ps
module quad_fold_wrap_tb_top;
    localparam int LAT = 12;
    localparam int HP  = 12868;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ang_valid;
    logic [15:0] ang_in;
    logic        core_valid;
    logic [15:0] core_angle;
    logic        core_res_valid;
    logic signed [15:0] core_res_x;
    logic signed [15:0] core_res_y;
    logic        out_valid;
    logic signed [15:0] out_cos;
    logic signed [15:0] out_sin;

    always #10 clk = ~clk;

    quad_fold_wrap #(.CORE_LAT(LAT), .HALF_PI_CODE(HP)) dut_i (
        .clk(clk), .rst_n(rst_n), .ang_valid(ang_valid), .ang_in(ang_in),
        .core_valid(core_valid), .core_angle(core_angle),
        .core_res_valid(core_res_valid), .core_res_x(core_res_x), .core_res_y(core_res_y),
        .out_valid(out_valid), .out_cos(out_cos), .out_sin(out_sin)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit    prev_v = 1'b0;
    int    prev_ang, prev_x, prev_y;
    bit    rsp_v [64];
    int    rsp_x [64];
    int    rsp_y [64];
    bit    exp_v [64];
    int    exp_c [64];
    int    exp_s [64];
    string exp_r [64];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic int negs(input int v);
        return (v == -32768) ? 32767 : -v;
    endfunction

    // expected restore from the quadrant table of R4..R8
    task automatic plan_out(input int slot, input int ang, input int x, input int y);
        int q;
        int c;
        int s;
        string r;
        q = ang >> 14;
        case (q)
            0: begin c = x;       s = y;       r = "R4"; end
            1: begin c = negs(y); s = x;       r = "R5"; end
            2: begin c = negs(x); s = negs(y); r = "R6"; end
            default: begin c = y; s = negs(x); r = "R7"; end
        endcase
        if ((q == 1 && y == -32768) || (q == 2 && (x == -32768 || y == -32768)) ||
            (q == 3 && x == -32768))
            r = {r, "/R8"};
        exp_v[slot] = 1'b1;
        exp_c[slot] = c;
        exp_s[slot] = s;
        exp_r[slot] = r;
    endtask

    // one clock: observe, model the core, drive the next input
    task automatic step(input bit v, input int ang, input int x, input int y);
        int sl;
        @(negedge clk);
        cyc++;
        sl = cyc % 64;
        chk(core_valid == prev_v, prev_v ? "R2 core_valid" : "R3 core_valid", int'(core_valid), int'(prev_v));
        if (prev_v && core_valid) begin
            chk(int'(core_angle) == (((prev_ang & 16383) * HP) >> 14), "R2 core_angle",
                int'(core_angle), ((prev_ang & 16383) * HP) >> 14);
            rsp_v[(cyc + LAT) % 64] = 1'b1;
            rsp_x[(cyc + LAT) % 64] = prev_x;
            rsp_y[(cyc + LAT) % 64] = prev_y;
            plan_out((cyc + LAT + 1) % 64, prev_ang, prev_x, prev_y);
        end
        chk(out_valid == exp_v[sl], "R9 out_valid", int'(out_valid), int'(exp_v[sl]));
        if (exp_v[sl] && out_valid) begin
            chk(int'(out_cos) == exp_c[sl], {exp_r[sl], " cos"}, int'(out_cos), exp_c[sl]);
            chk(int'(out_sin) == exp_s[sl], {exp_r[sl], " sin"}, int'(out_sin), exp_s[sl]);
        end
        exp_v[sl] = 1'b0;
        core_res_valid = rsp_v[sl];
        core_res_x     = 16'(rsp_v[sl] ? rsp_x[sl] : 0);
        core_res_y     = 16'(rsp_v[sl] ? rsp_y[sl] : 0);
        rsp_v[sl] = 1'b0;
        ang_valid = v;
        ang_in    = 16'(ang);
        prev_v    = v;
        prev_ang  = ang;
        prev_x    = x;
        prev_y    = y;
    endtask

    initial begin
        #(64'd200000 * 20);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) begin
            rsp_v[i] = 1'b0;
            exp_v[i] = 1'b0;
        end
        rst_n = 1'b0;
        ang_valid = 1'b0;
        ang_in = 16'h0;
        core_res_valid = 1'b0;
        core_res_x = '0;
        core_res_y = '0;
        // R1: reset state, with an input strobe held high during reset
        ang_valid = 1'b1;
        ang_in = 16'h9000;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(core_valid == 1'b0, "R1 core_valid", int'(core_valid), 0);
            chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        end
        ang_valid = 1'b0;
        rst_n = 1'b1;
        prev_v = 1'b0;

        // exact quadrant boundaries (R2, R4..R7)
        step(1, 16'h0000, 1000, -2000);
        step(1, 16'h3FFF, 30000, 5);
        step(1, 16'h4000, 32767, 1);
        step(1, 16'h7FFF, -3, 12345);
        step(1, 16'h8000, 20000, -20000);
        step(1, 16'hBFFF, 7, 8);
        step(1, 16'hC000, -100, 200);
        step(1, 16'hFFFF, 32767, -32767);
        // R8: saturating negation in each negating position
        step(1, 16'h8000, -32768, -32768);
        step(1, 16'h4001, 5, -32768);
        step(1, 16'hC000, -32768, 7);
        step(1, 16'h2000, -32768, -32768);
        // R3: idle cycles with a changing angle on the bus
        step(0, 16'hFFFF, 0, 0);
        step(0, 16'h5555, 0, 0);
        step(0, 16'hAAAA, 0, 0);
        // full-circle sweep with gaps (R2, R4..R7, R9)
        for (int a = 0; a < 65536; a += 97) begin
            step(1, a, ((a * 37 + 11) % 65536) - 32768, ((a * 53 + 5) % 65536) - 32768);
            if ((a / 97) % 5 == 4) step(0, a ^ 16'h3C3C, 0, 0);
        end
        // drain the core model
        for (int i = 0; i < LAT + 4; i++) step(0, 0, 0, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule